// File: doc/BRIEF.md
# Sync Status Flag and Interrupt Block

This block keeps the status flags of a clock-trimming controller and drives its single interrupt line. The trimming core sends one-cycle event pulses: sync OK, sync warning, expected sync, sync error, sync missed and trim overflow. Each pulse sets a sticky flag that stays set until software clears it. An aggregate error flag is derived from the three error causes: sync error, sync missed and trim overflow.

Software reaches the block through a simple write strobe with address and data, and through a combinational read port. The address map is:

| Address | Register | Access |
|---|---|---|
| 0 | Interrupt enables | read/write |
| 1 | Clear register | write-one-to-clear, reads zero |
| 2 | Status word | read-only |
| 3 | Unused | reads zero |

A clear bit for the error flag wipes all three error causes at once. The OK, warning and expected-sync flags each have their own clear bit. Four enables gate the OK, warning, error and expected-sync flags onto a registered interrupt output.

Top module: `sync_flag_ctrl`

## Requirements
- R1: After reset, every status bit, every enable bit and the interrupt output read zero.
- R2: An event pulse sets its flag, and the flag is visible in the status word after the next clock edge. Status bit positions are: 0 OK, 1 warning, 2 error, 3 expected sync, 4 sync error, 5 sync missed, 6 trim overflow. A set flag holds until it is cleared, and flags from separate pulses accumulate.
- R3: Status bit 2 (error) reads one exactly when at least one of status bits 4, 5 or 6 is set.
- R4: Writing address 1 affects the flags as follows. Data bit 0 clears OK, bit 1 clears warning and bit 3 clears expected sync. Bit 2 clears sync error, sync missed and trim overflow together, and so clears the error flag. Flags whose clear bit is zero are left unchanged.
- R5: When an event pulse and its clear arrive in the same cycle, the flag ends up set.
- R6: Writing zero to address 1 changes no flag, and reading address 1 returns zero.
- R7: Address 0 holds four interrupt enables that read back as written: bit 0 OK, bit 1 warning, bit 2 error, bit 3 expected sync.
- R8: The interrupt output is, one clock later, the OR over the four sources of (status bit AND enable bit). Status bits 0..3 pair with enable bits 0..3.
- R9: Writes to address 2 or address 3 change neither the flags nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ok | input | 1 | Sync OK event pulse |
| ev_warn | input | 1 | Sync warning event pulse |
| ev_expect | input | 1 | Expected-sync event pulse |
| ev_serr | input | 1 | Sync error event pulse |
| ev_miss | input | 1 | Sync missed event pulse |
| ev_tovf | input | 1 | Trim overflow/underflow event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CTRL_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | STATUS_W | Combinational read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench tries all 64 combinations of the six event pulses against all 16 enable settings. This shows that each event reaches its own status bit, that the error bit follows exactly the three causes, and that each enable gates only its own source onto the interrupt. All 16 clear patterns are applied to a fully set status word, which separates the grouped error clear from the individual clears and includes the all-zero write. Separate patterns cover accumulation of causes from distinct pulses, an event colliding with its clear, and writes to the read-only and unused addresses.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // status word bit positions
  localparam int ST_OK   = 0;
  localparam int ST_WARN = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_EXP  = 3;
  localparam int ST_SERR = 4;
  localparam int ST_MISS = 5;
  localparam int ST_TOVF = 6;
  localparam int STATUS_W = 7;

  // primary (stored) flag indices
  localparam int PF_OK   = 0;
  localparam int PF_WARN = 1;
  localparam int PF_EXP  = 2;
  localparam int PF_SERR = 3;
  localparam int PF_MISS = 4;
  localparam int PF_TOVF = 5;
  localparam int N_PRIM  = 6;

  // clear / enable bit positions
  localparam int CB_OK   = 0;
  localparam int CB_WARN = 1;
  localparam int CB_ERR  = 2;
  localparam int CB_EXP  = 3;
  localparam int CTRL_W  = 4;

  localparam logic [1:0] A_ENABLE = 2'd0;
  localparam logic [1:0] A_CLEAR  = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;

  function automatic logic any_err(input logic [2:0] causes);
    return |causes;
  endfunction

  function automatic logic irq_of(input logic [CTRL_W-1:0] src,
                                  input logic [CTRL_W-1:0] en);
    return |(src & en);
  endfunction

  function automatic logic [STATUS_W-1:0] pack_status(input logic [N_PRIM-1:0] p);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[ST_OK]   = p[PF_OK];
    s[ST_WARN] = p[PF_WARN];
    s[ST_EXP]  = p[PF_EXP];
    s[ST_SERR] = p[PF_SERR];
    s[ST_MISS] = p[PF_MISS];
    s[ST_TOVF] = p[PF_TOVF];
    s[ST_ERR]  = any_err({p[PF_TOVF], p[PF_MISS], p[PF_SERR]});
    return s;
  endfunction
endpackage

// File: rtl/sfc_sticky.sv
module sfc_sticky #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // event wins over clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_regif.sv
module sfc_regif
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [STATUS_W-1:0] status_i,
  output logic [CTRL_W-1:0]   ie_o,
  output logic [N_PRIM-1:0]   clr_o,
  output logic [STATUS_W-1:0] rd_data
);
  logic wr_ie, wr_clr;
  assign wr_ie  = wr_en && (wr_addr == ADDR_W'(A_ENABLE));
  assign wr_clr = wr_en && (wr_addr == ADDR_W'(A_CLEAR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_o <= '0;
    else if (wr_ie) ie_o <= wr_data;
  end

  always_comb begin
    clr_o = '0;
    if (wr_clr) begin
      clr_o[PF_OK]   = wr_data[CB_OK];
      clr_o[PF_WARN] = wr_data[CB_WARN];
      clr_o[PF_EXP]  = wr_data[CB_EXP];
      clr_o[PF_SERR] = wr_data[CB_ERR];
      clr_o[PF_MISS] = wr_data[CB_ERR];
      clr_o[PF_TOVF] = wr_data[CB_ERR];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_ENABLE))      rd_data = STATUS_W'(ie_o);
    else if (rd_addr == ADDR_W'(A_STATUS)) rd_data = status_i;
  end
endmodule

// File: rtl/sfc_irq.sv
module sfc_irq
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] src_i,
  input  logic [CTRL_W-1:0] en_i,
  output logic              irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_of(src_i, en_i);
  end
endmodule

// File: rtl/sync_flag_ctrl.sv
module sync_flag_ctrl
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_ok,
  input  logic                ev_warn,
  input  logic                ev_expect,
  input  logic                ev_serr,
  input  logic                ev_miss,
  input  logic                ev_tovf,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [STATUS_W-1:0] rd_data,
  output logic                irq
);
  // named internal events, used by the bound checker
  logic [N_PRIM-1:0]   set_vec;
  logic [N_PRIM-1:0]   clr_vec;
  logic [N_PRIM-1:0]   prim_q;
  logic [STATUS_W-1:0] status;
  logic [CTRL_W-1:0]   ie_q;

  always_comb begin
    set_vec          = '0;
    set_vec[PF_OK]   = ev_ok;
    set_vec[PF_WARN] = ev_warn;
    set_vec[PF_EXP]  = ev_expect;
    set_vec[PF_SERR] = ev_serr;
    set_vec[PF_MISS] = ev_miss;
    set_vec[PF_TOVF] = ev_tovf;
  end

  sfc_sticky #(.N(N_PRIM)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(prim_q)
  );

  assign status = pack_status(prim_q);

  sfc_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .status_i(status),
    .ie_o(ie_q), .clr_o(clr_vec), .rd_data(rd_data)
  );

  sfc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .src_i(status[CTRL_W-1:0]), .en_i(ie_q),
    .irq_o(irq)
  );
endmodule

// File: rtl/sync_flag_chk.sv
module sync_flag_chk
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [CTRL_W-1:0]   wr_data,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [STATUS_W-1:0] rd_data,
  input logic [N_PRIM-1:0]   set_vec,
  input logic [N_PRIM-1:0]   clr_vec,
  input logic [N_PRIM-1:0]   prim_q,
  input logic [STATUS_W-1:0] status,
  input logic [CTRL_W-1:0]   ie_q,
  input logic                irq
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((prim_q & $past(set_vec)) == $past(set_vec))); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((prim_q & ($past(prim_q) & ~$past(clr_vec))) == ($past(prim_q) & ~$past(clr_vec)))); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((prim_q & ~($past(prim_q) | $past(set_vec))) == '0)); // R2

  AST_ERR_GROUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_CLEAR) && wr_data[CB_ERR]) |->
      (clr_vec[PF_SERR] && clr_vec[PF_MISS] && clr_vec[PF_TOVF])); // R4

  AST_ERR_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_ERR]) |-> $past(wr_en && wr_addr == ADDR_W'(A_CLEAR) && wr_data[CB_ERR])); // R3

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status[CTRL_W-1:0] & ie_q)))); // R8

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(A_CLEAR)) |-> (rd_data == '0)); // R6

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_W'(A_ENABLE)) |=> $stable(ie_q)); // R9
endmodule

bind sync_flag_ctrl sync_flag_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .set_vec(set_vec), .clr_vec(clr_vec), .prim_q(prim_q),
  .status(status), .ie_q(ie_q), .irq(irq)
);

// File: tb/sync_flag_ctrl_bench.sv
`timescale 1ns/1ps
module sync_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_ok = 0, ev_warn = 0, ev_expect = 0, ev_serr = 0, ev_miss = 0, ev_tovf = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [3:0] wr_data = 0;
  logic [1:0] rd_addr = 0;
  logic [6:0] rd_data;
  logic       irq;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  sync_flag_ctrl u_sync_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_ok(ev_ok), .ev_warn(ev_warn),
    .ev_expect(ev_expect), .ev_serr(ev_serr), .ev_miss(ev_miss),
    .ev_tovf(ev_tovf), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // event bits: 0 ok, 1 warn, 2 expect, 3 serr, 4 miss, 5 tovf
  function automatic logic [6:0] model_status(input logic [5:0] e);
    return {e[5], e[4], e[3], e[2], (e[3] | e[4] | e[5]), e[1], e[0]};
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [5:0] e);
    {ev_tovf, ev_miss, ev_serr, ev_expect, ev_warn, ev_ok} = e;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic pulse(input logic [5:0] e);
    drive_ev(e);
    @(negedge clk);
    drive_ev(6'd0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [6:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0] v;
    logic [6:0] expv;
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R1 status", v, 7'h00);
    rd(2'd0, v); chk("R1 enable", v, 7'h00);
    chk("R1 irq", {6'd0, irq}, 7'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 enable readback
    for (int en = 0; en < 16; en++) begin
      wr(2'd0, 4'(en));
      rd(2'd0, v); chk("R7 enable readback", v, 7'(en));
    end

    // R2 R3 R8 exhaustive events x enables
    for (int en = 0; en < 16; en++) begin
      for (int e = 0; e < 64; e++) begin
        wr(2'd1, 4'hF);
        wr(2'd0, 4'(en));
        pulse(6'(e));
        expv = model_status(6'(e));
        rd(2'd2, v); chk("R2/R3 status after events", v, expv);
        @(negedge clk);
        chk("R8 irq", {6'd0, irq}, {6'd0, |(expv[3:0] & 4'(en))});
      end
    end

    // R4 R6 clear patterns on full status
    for (int c = 0; c < 16; c++) begin
      wr(2'd1, 4'hF);
      pulse(6'h3F);
      wr(2'd1, 4'(c));
      expv = {{3{~c[2]}}, ~c[3], ~c[2], ~c[1], ~c[0]};
      rd(2'd2, v); chk(c == 0 ? "R6 zero write no effect" : "R4 clear pattern", v, expv);
      rd(2'd1, v); chk("R6 clear reads zero", v, 7'h00);
    end

    // R2 accumulation of causes from separate pulses
    wr(2'd1, 4'hF);
    pulse(6'h08);
    pulse(6'h20);
    rd(2'd2, v); chk("R2 accumulate", v, 7'h54);
    pulse(6'h01);
    rd(2'd2, v); chk("R2 hold and accumulate", v, 7'h55);
    wr(2'd1, 4'h4);
    rd(2'd2, v); chk("R4 group clear keeps ok", v, 7'h01);

    // R5 event vs clear in same cycle
    wr(2'd1, 4'hF);
    pulse(6'h3F);
    drive_ev(6'h11);
    wr(2'd1, 4'hF);
    drive_ev(6'h00);
    rd(2'd2, v); chk("R5 event wins", v, 7'h25);

    // R8 irq drops after clear
    wr(2'd0, 4'h1);
    wr(2'd1, 4'hF);
    pulse(6'h01);
    @(negedge clk);
    chk("R8 irq set", {6'd0, irq}, 7'h01);
    wr(2'd1, 4'h1);
    @(negedge clk);
    chk("R8 irq cleared", {6'd0, irq}, 7'h00);

    // R9 writes to status and unused address
    wr(2'd0, 4'h6);
    wr(2'd1, 4'hF);
    wr(2'd2, 4'hF);
    rd(2'd2, v); chk("R9 status write ignored", v, 7'h00);
    wr(2'd3, 4'hF);
    rd(2'd0, v); chk("R9 enable unchanged", v, 7'h06);
    rd(2'd3, v); chk("R9 unused reads zero", v, 7'h00);
    pulse(6'h3F);
    wr(2'd2, 4'hF);
    wr(2'd3, 4'hF);
    rd(2'd2, v); chk("R9 full status kept", v, 7'h7F);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule